// File: doc/BRIEF.md
# Register-Addressed Serial Control Port

This block is a synchronous serial slave. A host reaches up to eight core-side registers through it. Every access starts with a control byte, called the command byte here, which the host shifts into an internal 8-bit command register. That byte names the target register, gives the direction of the next access and carries a channel field that is passed on to the core. The data phase follows, and after it the port waits for a new command byte. Framing does not depend on chip select: the port remembers whether it expects a command byte or a data phase. A run of ones on the data line puts a lost host back into step.

The serial pins (select, clock, data in) are sampled with the system clock through synchronizers. A polarity input chooses which serial clock edge captures input bits and which edge launches output bits. On the core side the port gives a register address, a channel field, a one-cycle write strobe with right-justified write data, and a right-justified read data input. A data-ready output tells the host that a fresh result is waiting in the result register. With select tied low, the host can poll that flag as the top bit of the command register.

Top module: `sif_ctrl_top`

## Requirements
- R1: After reset `rdy_n_o` is 1, `sdo_o` is 0, no write strobe fires, and the first 8 bits shifted in are taken as a command byte.
- R2: Command byte layout: bits [6:4] select the register, bit 3 selects read (1) or write (0), bits [2:0] appear on `rf_chan_o`. Select 000 addresses the command register. Reading it returns {rdy_n, select, dir, channel}, with bit 7 equal to the current `rdy_n_o`.
- R3: When a data phase completes, the next bits are again taken as a command byte. A command write with select 000 and dir 0 has no data phase.
- R4: The write data length is 8 bits for selects 1 to 4. For selects 5 to 7 it is 24 bits when `word24_i` is 1 and 16 bits when it is 0. Data arrives MSB first. A completed write gives exactly one `rf_wr_en_o` pulse, with `rf_addr_o` set to the select and `rf_wdata_o` holding the bits right-justified.
- R5: A read phase shifts out, MSB first, the low bits of `rf_rdata_i` for the selected register. The number of bits follows the length rule of R4.
- R6: When `pol_i` is 1, bits are captured on rising `sclk_i` edges and launched on falling edges. When `pol_i` is 0 the two edges swap.
- R7: Raising `csn_i` in the middle of a phase discards the partial bits and keeps the phase. After select returns, the phase restarts from its first bit, and a read restarts from the MSB.
- R8: After 32 consecutive captured ones the port expects a command byte. No write strobe results from the ones that complete that run.
- R9: `rdy_n_o` goes to 0 one cycle after an `upd_done_i` pulse. It goes to 1 after an `upd_soon_i` pulse, and also after a complete read of register 5 (the result register).
- R10: Reading register 5 again after `rdy_n_o` has risen returns the same word.
- R11: With `csn_i` held low across several transactions (three-wire use), command bytes, data phases and status polls keep working back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| pol_i | input | 1 | Serial clock polarity select |
| sdo_o | output | 1 | Serial data to host |
| rdy_n_o | output | 1 | Data-ready flag, active low |
| word24_i | input | 1 | Wide register length: 1 gives 24 bits, 0 gives 16 bits |
| upd_soon_i | input | 1 | Pulse: result register is about to change |
| upd_done_i | input | 1 | Pulse: new result stored |
| rf_addr_o | output | 3 | Selected register address |
| rf_chan_o | output | 3 | Channel field of last command byte |
| rf_wr_en_o | output | 1 | One-cycle register write strobe |
| rf_wdata_o | output | 24 | Right-justified write data |
| rf_rdata_i | input | 24 | Right-justified read data for `rf_addr_o` |

## Verification
The bench uses the default parameters: 24-bit wide words, a 16-bit narrow alternative, two synchronizer stages and a 32-bit resync run. It toggles `word24_i` between transactions, so all three phase lengths (8, 16 and 24) are reached in both directions. The 32-bit run is longer than the longest data phase, so a read of the result register filled with ones carries the resync count into the next command byte. That exercises the case where the run completes on the same edge that would finish a byte. With the sync depth at two and six system cycles per serial half-period, every launched bit settles before the host samples it under both polarities.

// File: rtl/sif_pkg.sv
package sif_pkg;
   localparam int COMM_W  = 8;
   localparam int SEL_W   = 3;
   localparam int SEL_LSB = 4;
   localparam int DIR_BIT = 3;
   localparam int CHAN_W  = 3;

   typedef enum logic [1:0] {
      PH_CMD   = 2'd0,
      PH_READ  = 2'd1,
      PH_WRITE = 2'd2
   } phase_e;
endpackage

// File: rtl/sif_sync_edge.sv
module sif_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdi_i,
   input  logic csn_i,
   input  logic pol_i,
   output logic smp_stb_o,
   output logic lch_stb_o,
   output logic sdi_o,
   output logic csn_o
);
   localparam int GUARD = STAGES + 1;

   // each stage carries {sclk, sdi, csn}
   logic [2:0]       pipe [STAGES];
   logic             sclk_d;
   logic [GUARD-1:0] arm_q;
   logic             sclk_s, rise, fall, active;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= 3'b001;
            else        pipe[0] <= {sclk_i, sdi_i, csn_i};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= 3'b001;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         arm_q  <= '0;
      end else begin
         sclk_d <= sclk_s;
         arm_q  <= {arm_q[GUARD-2:0], 1'b1};
      end
   end

   always_comb begin
      sclk_s    = pipe[STAGES-1][2];
      sdi_o     = pipe[STAGES-1][1];
      csn_o     = pipe[STAGES-1][0];
      rise      = sclk_s & ~sclk_d;
      fall      = ~sclk_s & sclk_d;
      active    = arm_q[GUARD-1] & ~csn_o;
      smp_stb_o = active & (pol_i ? rise : fall);
      lch_stb_o = active & (pol_i ? fall : rise);
   end
endmodule

// File: rtl/sif_resync.sv
module sif_resync #(
   parameter int RUN_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_stb_i,
   input  logic sdi_i,
   input  logic csn_i,
   output logic hit_o
);
   localparam int CW = $clog2(RUN_LEN + 1);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (csn_i)
         run_q <= '0;
      else if (smp_stb_i) begin
         if (!sdi_i)                      run_q <= '0;
         else if (run_q != CW'(RUN_LEN))  run_q <= run_q + 1'b1;
      end
   end

   // this captured one is the RUN_LEN-th (or later) of an unbroken run
   assign hit_o = smp_stb_i & sdi_i & (run_q >= CW'(RUN_LEN - 1));

   p_run_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> (run_q == CW'(RUN_LEN)));
endmodule

// File: rtl/sif_frame.sv
module sif_frame
   import sif_pkg::*;
#(
   parameter int WIDE_W     = 24,
   parameter int NARROW_W   = 16,
   parameter int DATA_SEL   = 5,
   parameter int CAL_SEL_LO = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_stb_i,
   input  logic              lch_stb_i,
   input  logic              sdi_i,
   input  logic              csn_i,
   input  logic              resync_i,
   input  logic              word24_i,
   input  logic              rdy_n_i,
   input  logic [WIDE_W-1:0] rf_rdata_i,
   output logic [SEL_W-1:0]  rf_addr_o,
   output logic [CHAN_W-1:0] rf_chan_o,
   output logic              rf_wr_en_o,
   output logic [WIDE_W-1:0] rf_wdata_o,
   output logic              sdo_o,
   output logic              data_rd_done_o
);
   localparam int CNT_W = $clog2(WIDE_W + 1);

   function automatic logic [CNT_W-1:0] len_of(input logic [SEL_W-1:0] s, input logic w24);
      if (s == SEL_W'(DATA_SEL) || s >= SEL_W'(CAL_SEL_LO))
         return w24 ? CNT_W'(WIDE_W) : CNT_W'(NARROW_W);
      return CNT_W'(COMM_W);
   endfunction

   phase_e              state_q;
   logic [CNT_W-1:0]    cnt_q, plen_q, cnt_next, tx_shift;
   logic [WIDE_W-1:0]   rx_q, rx_next, tx_q, load_val;
   logic [SEL_W-1:0]    sel_q, new_sel;
   logic [CHAN_W-1:0]   chan_q, new_chan;
   logic                dir_q, new_dir, ld_pend_q;
   logic                in_cmd, last_bit, cmd_done, phase_done, cmd_has_data;

   always_comb begin
      rx_next      = {rx_q[WIDE_W-2:0], sdi_i};
      cnt_next     = cnt_q + 1'b1;
      new_sel      = rx_next[SEL_LSB +: SEL_W];
      new_dir      = rx_next[DIR_BIT];
      new_chan     = rx_next[CHAN_W-1:0];
      in_cmd       = (state_q == PH_CMD);
      last_bit     = smp_stb_i && !resync_i &&
                     (cnt_next == (in_cmd ? CNT_W'(COMM_W) : plen_q));
      cmd_done     = last_bit && in_cmd;
      phase_done   = last_bit && !in_cmd;
      cmd_has_data = !(new_sel == '0 && !new_dir);
      tx_shift     = CNT_W'(WIDE_W) - plen_q;
      load_val     = (sel_q == '0) ? WIDE_W'({rdy_n_i, sel_q, dir_q, chan_q}) : rf_rdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= PH_CMD;
         cnt_q          <= '0;
         plen_q         <= CNT_W'(COMM_W);
         rx_q           <= '0;
         tx_q           <= '0;
         sel_q          <= '0;
         dir_q          <= 1'b0;
         chan_q         <= '0;
         ld_pend_q      <= 1'b0;
         sdo_o          <= 1'b0;
         rf_wr_en_o     <= 1'b0;
         rf_wdata_o     <= '0;
         data_rd_done_o <= 1'b0;
      end else begin
         rf_wr_en_o     <= 1'b0;
         data_rd_done_o <= 1'b0;

         if (resync_i) begin
            state_q <= PH_CMD;
            cnt_q   <= '0;
            rx_q    <= '0;
         end else if (csn_i) begin
            cnt_q <= '0;
            rx_q  <= '0;
            if (state_q == PH_READ) ld_pend_q <= 1'b1;
         end else if (smp_stb_i) begin
            if (last_bit) begin
               cnt_q <= '0;
               rx_q  <= '0;
               if (in_cmd) begin
                  sel_q  <= new_sel;
                  dir_q  <= new_dir;
                  chan_q <= new_chan;
                  plen_q <= len_of(new_sel, word24_i);
                  if (cmd_has_data) begin
                     state_q   <= new_dir ? PH_READ : PH_WRITE;
                     ld_pend_q <= new_dir;
                  end
               end else begin
                  state_q <= PH_CMD;
                  if (state_q == PH_WRITE) begin
                     rf_wr_en_o <= 1'b1;
                     rf_wdata_o <= rx_next;
                  end else if (sel_q == SEL_W'(DATA_SEL)) begin
                     data_rd_done_o <= 1'b1;
                  end
               end
            end else begin
               cnt_q <= cnt_next;
               rx_q  <= rx_next;
            end
         end

         // transmit path: left-align the word one cycle after the address settles
         if (ld_pend_q && state_q == PH_READ && !csn_i) begin
            tx_q      <= load_val << tx_shift;
            ld_pend_q <= 1'b0;
         end else if (lch_stb_i && state_q == PH_READ) begin
            tx_q <= {tx_q[WIDE_W-2:0], 1'b0};
         end

         if (state_q != PH_READ || csn_i) sdo_o <= 1'b0;
         else if (lch_stb_i)              sdo_o <= tx_q[WIDE_W-1];
      end
   end

   assign rf_addr_o = sel_q;
   assign rf_chan_o = chan_q;

   p_resync_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resync_i |=> (state_q == PH_CMD && cnt_q == '0));
   p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      csn_i |=> (cnt_q == '0));
   p_wr_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en_o |-> (state_q == PH_CMD && !$past(rf_wr_en_o)));
   p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en_o |=> !rf_wr_en_o);
   p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != PH_CMD) |-> (cnt_q < plen_q));
endmodule

// File: rtl/sif_ctrl_top.sv
module sif_ctrl_top
   import sif_pkg::*;
#(
   parameter int WIDE_W      = 24,
   parameter int NARROW_W    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int RUN_LEN     = 32,
   parameter int DATA_SEL    = 5,
   parameter int CAL_SEL_LO  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn_i,
   input  logic              sclk_i,
   input  logic              sdi_i,
   input  logic              pol_i,
   output logic              sdo_o,
   output logic              rdy_n_o,
   input  logic              word24_i,
   input  logic              upd_soon_i,
   input  logic              upd_done_i,
   output logic [2:0]        rf_addr_o,
   output logic [2:0]        rf_chan_o,
   output logic              rf_wr_en_o,
   output logic [WIDE_W-1:0] rf_wdata_o,
   input  logic [WIDE_W-1:0] rf_rdata_i
);
   if (COMM_W != 2 + SEL_W + CHAN_W) begin : g_bad_fmt
      $error("command byte fields do not fill the command register");
   end
   if (NARROW_W < COMM_W || WIDE_W <= NARROW_W) begin : g_bad_width
      $error("need COMM_W <= NARROW_W < WIDE_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RUN_LEN < 2) begin : g_bad_run
      $error("RUN_LEN must be at least 2");
   end
   if (DATA_SEL < 1 || DATA_SEL >= (1 << SEL_W) || CAL_SEL_LO >= (1 << SEL_W)) begin : g_bad_sel
      $error("register selects out of range");
   end

   logic smp_stb, lch_stb, sdi_s, csn_s, resync, data_rd_done;

   sif_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk_i),
      .sdi_i     (sdi_i),
      .csn_i     (csn_i),
      .pol_i     (pol_i),
      .smp_stb_o (smp_stb),
      .lch_stb_o (lch_stb),
      .sdi_o     (sdi_s),
      .csn_o     (csn_s)
   );

   sif_resync #(.RUN_LEN(RUN_LEN)) u_resync (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_stb_i (smp_stb),
      .sdi_i     (sdi_s),
      .csn_i     (csn_s),
      .hit_o     (resync)
   );

   sif_frame #(
      .WIDE_W     (WIDE_W),
      .NARROW_W   (NARROW_W),
      .DATA_SEL   (DATA_SEL),
      .CAL_SEL_LO (CAL_SEL_LO)
   ) u_frame (
      .clk            (clk),
      .rst_n          (rst_n),
      .smp_stb_i      (smp_stb),
      .lch_stb_i      (lch_stb),
      .sdi_i          (sdi_s),
      .csn_i          (csn_s),
      .resync_i       (resync),
      .word24_i       (word24_i),
      .rdy_n_i        (rdy_n_o),
      .rf_rdata_i     (rf_rdata_i),
      .rf_addr_o      (rf_addr_o),
      .rf_chan_o      (rf_chan_o),
      .rf_wr_en_o     (rf_wr_en_o),
      .rf_wdata_o     (rf_wdata_o),
      .sdo_o          (sdo_o),
      .data_rd_done_o (data_rd_done)
   );

   // data-ready flag: a new result wins over a clearing event in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rdy_n_o <= 1'b1;
      else if (upd_done_i)                 rdy_n_o <= 1'b0;
      else if (upd_soon_i || data_rd_done) rdy_n_o <= 1'b1;
   end

   p_rdy_new_r9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done_i |=> !rdy_n_o);
   p_rdy_soon_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_soon_i && !upd_done_i) |=> rdy_n_o);
   p_rdy_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_done && !upd_done_i) |=> rdy_n_o);
endmodule

// File: tb/sif_ctrl_top_tb_top.sv
module sif_ctrl_top_tb_top;
   localparam int HALF = 6;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        csn = 1'b1, sclk = 1'b1, sdi = 1'b0, pol = 1'b1;
   logic        word24 = 1'b1, upd_soon = 1'b0, upd_done = 1'b0;
   logic        sdo, rdy_n, rf_wr_en;
   logic [2:0]  rf_addr, rf_chan;
   logic [23:0] rf_wdata, rf_rdata;
   logic [23:0] model [8];
   logic [26:0] exp_q [$];
   logic [26:0] mon_e;
   logic [23:0] v;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;
   assign rf_rdata = model[rf_addr];

   sif_ctrl_top dut_i (
      .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi), .pol_i(pol),
      .sdo_o(sdo), .rdy_n_o(rdy_n), .word24_i(word24), .upd_soon_i(upd_soon),
      .upd_done_i(upd_done), .rf_addr_o(rf_addr), .rf_chan_o(rf_chan),
      .rf_wr_en_o(rf_wr_en), .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every write strobe must match the next expected item
   always @(negedge clk) begin
      if (rst_n && rf_wr_en) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R4/R8 unexpected write: got %h expected none", {rf_addr, rf_wdata});
         end else begin
            mon_e = exp_q.pop_front();
            chk("R4 write addr/data", {5'd0, rf_addr, rf_wdata}, {5'd0, mon_e});
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [23:0] din, input int n, output logic [23:0] dout);
      dout = '0;
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         sclk = ~pol;          // launch edge
         sdi  = din[i];
         tick(HALF);
         dout[i] = sdo;
         sclk = pol;           // capture edge
         tick(HALF);
      end
   endtask

   task automatic cs(input logic val);
      @(negedge clk);
      csn = val;
      tick(4);
   endtask

   task automatic cmd(input logic [2:0] sel, input logic dir, input logic [2:0] chan);
      logic [23:0] d;
      xfer({16'd0, 1'b0, sel, dir, chan}, 8, d);
   endtask

   task automatic wr_reg(input logic [2:0] sel, input logic [2:0] chan,
                         input logic [23:0] data, input int n);
      logic [23:0] d;
      cs(1'b0);
      cmd(sel, 1'b0, chan);
      exp_q.push_back({sel, data});
      xfer(data, n, d);
      cs(1'b1);
   endtask

   task automatic rd_reg(input logic [2:0] sel, input logic [2:0] chan,
                         input int n, output logic [23:0] dout);
      cs(1'b0);
      cmd(sel, 1'b1, chan);
      xfer(24'd0, n, dout);
      cs(1'b1);
   endtask

   task automatic pulse_done();
      @(negedge clk); upd_done = 1'b1;
      @(negedge clk); upd_done = 1'b0;
      tick(2);
   endtask

   task automatic pulse_soon();
      @(negedge clk); upd_soon = 1'b1;
      @(negedge clk); upd_soon = 1'b0;
      tick(2);
   endtask

   task automatic set_pol(input logic p);
      @(negedge clk);
      pol  = p;
      sclk = p;
      tick(6);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) model[i] = 24'd0;
      tick(3);
      rst_n = 1'b1;
      tick(6);

      // R1 reset state
      chk("R1 rdy_n after reset", {31'd0, rdy_n}, 32'd1);
      chk("R1 sdo after reset", {31'd0, sdo}, 32'd0);
      chk("R1 no write after reset", {31'd0, rf_wr_en}, 32'd0);

      // R1/R2/R4: first byte is a command, 8-bit write to register 2, channel 3
      wr_reg(3'd2, 3'd3, 24'h0000A5, 8);
      chk("R2 channel field", {29'd0, rf_chan}, 32'd3);

      // R5 8-bit read
      model[2] = 24'h00005C;
      rd_reg(3'd2, 3'd1, 8, v);
      chk("R5 read reg2", {8'd0, v}, 32'h5C);
      chk("R2 channel update", {29'd0, rf_chan}, 32'd1);

      // R3 back-to-back transactions within one select window
      model[3] = 24'h000042;
      cs(1'b0);
      cmd(3'd3, 1'b0, 3'd0);
      exp_q.push_back({3'd3, 24'h000081});
      xfer(24'h000081, 8, v);
      cmd(3'd3, 1'b1, 3'd0);
      xfer(24'd0, 8, v);
      cs(1'b1);
      chk("R3 return to command after write", {8'd0, v}, 32'h42);

      // R4 wide lengths
      word24 = 1'b1;
      wr_reg(3'd6, 3'd0, 24'h123456, 24);
      word24 = 1'b0;
      wr_reg(3'd7, 3'd0, 24'h00BEEF, 16);
      model[7] = 24'h00ABCD;
      rd_reg(3'd7, 3'd0, 16, v);
      chk("R5 16-bit read", {8'd0, v}, 32'hABCD);
      word24 = 1'b1;

      // R9 data-ready handshake and R2 status bit
      model[5] = 24'hC0FFEE;
      pulse_done();
      chk("R9 rdy low on new result", {31'd0, rdy_n}, 32'd0);
      rd_reg(3'd0, 3'd2, 8, v);
      chk("R2 status poll ready", {8'd0, v}, 32'h0A);
      rd_reg(3'd5, 3'd2, 24, v);
      chk("R5 result read", {8'd0, v}, 32'hC0FFEE);
      chk("R9 rdy high after result read", {31'd0, rdy_n}, 32'd1);
      rd_reg(3'd5, 3'd2, 24, v);
      chk("R10 result reread", {8'd0, v}, 32'hC0FFEE);
      rd_reg(3'd0, 3'd2, 8, v);
      chk("R2 status poll not ready", {8'd0, v}, 32'h8A);
      pulse_done();
      pulse_soon();
      chk("R9 rdy high on update warning", {31'd0, rdy_n}, 32'd1);

      // R6 inverted clock sense
      set_pol(1'b0);
      wr_reg(3'd1, 3'd4, 24'h00003C, 8);
      model[1] = 24'h000096;
      rd_reg(3'd1, 3'd4, 8, v);
      chk("R6 read with pol 0", {8'd0, v}, 32'h96);
      rd_reg(3'd5, 3'd4, 24, v);
      chk("R6 wide read with pol 0", {8'd0, v}, 32'hC0FFEE);
      set_pol(1'b1);

      // R7 select abort mid write, mid read, mid command
      cs(1'b0);
      cmd(3'd2, 1'b0, 3'd0);
      xfer(24'h000007, 3, v);
      cs(1'b1);
      cs(1'b0);
      exp_q.push_back({3'd2, 24'h00006B});
      xfer(24'h00006B, 8, v);
      cs(1'b1);
      cs(1'b0);
      cmd(3'd2, 1'b1, 3'd0);
      xfer(24'd0, 5, v);
      cs(1'b1);
      cs(1'b0);
      xfer(24'd0, 8, v);
      cs(1'b1);
      chk("R7 read restarts from MSB", {8'd0, v}, 32'h5C);
      cs(1'b0);
      xfer(24'h000005, 4, v);
      cs(1'b1);
      wr_reg(3'd4, 3'd5, 24'h000011, 8);
      chk("R7 command restart", {29'd0, rf_chan}, 32'd5);

      // R8 run of ones resynchronises without a write
      cs(1'b0);
      cmd(3'd5, 1'b1, 3'd0);
      xfer(24'hFFFFFF, 24, v);
      xfer(24'h00FFFF, 16, v);
      cmd(3'd2, 1'b1, 3'd0);
      xfer(24'd0, 8, v);
      cs(1'b1);
      chk("R8 command after resync", {8'd0, v}, 32'h5C);
      chk("R8 no pending writes", exp_q.size(), 32'd0);

      // R11 three-wire: select held low throughout
      cs(1'b0);
      pulse_done();
      cmd(3'd0, 1'b1, 3'd6);
      xfer(24'd0, 8, v);
      chk("R11 poll ready", {8'd0, v}, 32'h0E);
      cmd(3'd5, 1'b1, 3'd6);
      xfer(24'd0, 24, v);
      chk("R11 result read", {8'd0, v}, 32'hC0FFEE);
      cmd(3'd0, 1'b1, 3'd6);
      xfer(24'd0, 8, v);
      chk("R11 poll after read", {8'd0, v}, 32'h8E);
      cmd(3'd1, 1'b0, 3'd6);
      exp_q.push_back({3'd1, 24'h000077});
      xfer(24'h000077, 8, v);
      cs(1'b1);
      tick(4);
      chk("R4 all expected writes seen", exp_q.size(), 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1-watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule